// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the SCL clock for an I2C master. It counts a programmable number of operating-clock cycles for the low phase and another for the high phase. The operating clock is the system clock, or the system clock divided by two when the prescale select is set. The select must be set whenever the system clock runs above 20 MHz, so that the operating clock stays at or below that rate.

The output is open-drain in style. A single output requests that the line be pulled low, and deasserting it releases the line. The block never drives SCL high. Each phase count starts only once the sensed SCL input, taken through a synchronizer, shows that the line has reached the new level. Bus rise and fall times, and a slave holding SCL low, therefore lengthen the period and do not shorten either count. The SCL frequency is the operating clock divided by (low count + high count + the edge times in operating cycles), plus a fixed synchronizer latency. The block gives a one-cycle strobe on each sensed falling edge and each sensed rising edge for the data-shift logic. START/STOP sequencing, data, acknowledge and arbitration sit outside this block.

Top module: `scl_clkgen`

## Requirements
- R1: With an ideal bus, the low phase keeps `scl_pull_low` at 1 for exactly Leff×P + SYNC_STAGES + 1 system cycles. Leff is `low_count`, with 0 read as 1. P is 1, or 2 when `half_rate` is 1.
- R2: With an ideal bus, the high phase keeps `scl_pull_low` at 0 for exactly Heff×P + SYNC_STAGES + 1 system cycles. Heff is `high_count`, with 0 read as 1.
- R3: A phase count starts only after `scl_sense` shows the new level. A bus delay of D cycles on both edges adds D to each phase. A slave holding SCL low for K cycles after release adds K to the high phase.
- R4: When `half_rate` is 1, the operating clock is half the system clock, so every count lasts twice as many system cycles.
- R5: A count of 0 in either register gives a phase of one operating cycle, never zero.
- R6: When `enable` is sampled low, `scl_pull_low` is 0 from the next cycle on. Generation restarts with a low phase when `enable` returns to 1.
- R7: `fall_strobe` pulses for one cycle exactly once in each low phase. `rise_strobe` pulses for one cycle exactly once in each high phase. The two are never high together.
- R8: After reset, `scl_pull_low`, `rise_strobe` and `fall_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the clock generator when 1 |
| half_rate | input | 1 | 1 selects operating clock = system clock / 2 |
| low_count | input | CNT_W | Low-phase length in operating cycles |
| high_count | input | CNT_W | High-phase length in operating cycles |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| rise_strobe | output | 1 | One-cycle pulse on a sensed rising edge |
| fall_strobe | output | 1 | One-cycle pulse on a sensed falling edge |

## Verification
The assertions assume that `low_count`, `high_count` and `half_rate` do not change while a phase is being counted. They also assume that the sensed line follows the pull request, perhaps after a delay or a slave hold. The bench changes the settings only while `enable` is low, and it leaves enough idle cycles for the synchronized line to settle high again. Its bus model is the inverse of the pull request, delayed by a chosen number of cycles and optionally held low by a modelled slave. As a result, every stretch it applies falls within the high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [2:0] {
    PH_OFF,
    PH_LO_WAIT,
    PH_LO_RUN,
    PH_HI_WAIT,
    PH_HI_RUN
  } scl_phase_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scl_tick.sv
module scl_tick (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic half_sel,
  output logic tick
);
  logic sub;

  always_ff @(posedge clk) begin
    if (rst || clear) sub <= 1'b0;
    else              sub <= ~sub;
  end

  assign tick = half_sel ? sub : 1'b1;

  // R4: at half rate, two ticks never fall in consecutive cycles
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (half_sel && tick) |=> (!tick || !half_sel));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W:0]   nxt;

  assign lim_eff = (limit == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit;
  assign nxt     = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign done    = run && tick && (nxt >= {1'b0, lim_eff});

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (done)    cnt <= '0;
    else if (tick)    cnt <= nxt[CNT_W-1:0];
  end

  // R5: the running count stays below the effective (nonzero) limit
  a_r5_cnt_below_limit: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < lim_eff));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             half_rate,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             rise_strobe,
  output logic             fall_strobe
);
  scl_phase_t       state, nxt;
  logic             line_hi;
  logic             run;
  logic             tick;
  logic             done;
  logic [CNT_W-1:0] limit;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(scl_sense), .q(line_hi)
  );

  assign run   = (state == PH_LO_RUN) || (state == PH_HI_RUN);
  assign limit = (state == PH_LO_RUN) ? low_count : high_count;

  scl_tick u_tick (
    .clk(clk), .rst(rst), .clear(!run), .half_sel(half_rate), .tick(tick)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .limit(limit), .done(done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      PH_OFF:     nxt = PH_LO_WAIT;
      PH_LO_WAIT: if (!line_hi) nxt = PH_LO_RUN;
      PH_LO_RUN:  if (done)     nxt = PH_HI_WAIT;
      PH_HI_WAIT: if (line_hi)  nxt = PH_HI_RUN;
      PH_HI_RUN:  if (done)     nxt = PH_LO_WAIT;
      default:    nxt = PH_OFF;
    endcase
    if (!enable) nxt = PH_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= PH_OFF;
      scl_pull_low <= 1'b0;
      rise_strobe  <= 1'b0;
      fall_strobe  <= 1'b0;
    end else begin
      state        <= nxt;
      scl_pull_low <= (nxt == PH_LO_WAIT) || (nxt == PH_LO_RUN);
      fall_strobe  <= (state == PH_LO_WAIT) && (nxt == PH_LO_RUN);
      rise_strobe  <= (state == PH_HI_WAIT) && (nxt == PH_HI_RUN);
    end
  end

  // R6: disabling releases the line on the next cycle
  a_r6_release_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !scl_pull_low);
  // R7: strobes are exclusive and tied to the driven phase
  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_strobe && fall_strobe));
  a_r7_fall_in_low: assert property (@(posedge clk) disable iff (rst)
    fall_strobe |-> scl_pull_low);
  a_r7_rise_in_high: assert property (@(posedge clk) disable iff (rst)
    rise_strobe |-> !scl_pull_low);
  // R3: while the released line is still sensed low, counting does not begin
  a_r3_wait_for_line: assert property (@(posedge clk) disable iff (rst)
    (state == PH_HI_WAIT && !line_hi && enable) |=> (state == PH_HI_WAIT));
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  localparam int CW   = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic half = 1'b0;
  logic [CW-1:0] lo_c = '0;
  logic [CW-1:0] hi_c = '0;
  logic pull, rise_s, fall_s;
  logic [3:0] dline = 4'b1111;
  logic hold = 1'b0;
  logic bus, sense;
  int   dly = 0;
  int   stretch_k = 0;

  int n_checks = 0;
  int n_fail   = 0;

  int    exp_len[$];
  bit    exp_low[$];
  string cur_tag = "";
  bit    mon_on = 1'b0;
  bit    started = 1'b0;
  logic  prev = 1'b0;
  int    seg_len = 0;
  int    n_fall = 0;
  int    n_rise = 0;
  int    hold_left = 0;

  always #10 clk = ~clk;

  scl_clkgen #(.CNT_W(CW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .enable(en), .half_rate(half),
    .low_count(lo_c), .high_count(hi_c), .scl_sense(sense),
    .scl_pull_low(pull), .rise_strobe(rise_s), .fall_strobe(fall_s)
  );

  always @(posedge clk) dline <= {dline[2:0], ~pull};
  assign bus   = (dly == 0) ? ~pull : dline[dly-1];
  assign sense = bus & ~hold;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures each phase length and strobe count, compares to queue
  always @(negedge clk) begin
    if (hold_left > 0) begin
      hold_left = hold_left - 1;
      if (hold_left == 0) hold = 1'b0;
    end
    if (mon_on) begin
      if (pull !== prev) begin
        if (started && exp_len.size() > 0) begin
          int  e;
          bit  lw;
          e  = exp_len.pop_front();
          lw = exp_low.pop_front();
          check({cur_tag, lw ? " low length" : " high length"}, seg_len, e);
          check({cur_tag, " R7 strobe count"}, lw ? n_fall : n_rise, 1);
          check({cur_tag, " R7 wrong strobe"}, lw ? n_rise : n_fall, 0);
          if (exp_len.size() == 0) mon_on = 1'b0;
        end
        started = 1'b1;
        seg_len = 1;
        n_fall  = 0;
        n_rise  = 0;
        if (pull == 1'b0 && stretch_k > 0) begin
          hold      = 1'b1;
          hold_left = stretch_k;
        end
      end else begin
        seg_len++;
      end
      if (fall_s) n_fall++;
      if (rise_s) n_rise++;
    end
    prev = pull;
  end

  task automatic run_case(input string tag, input int l, input int h,
                          input bit dv, input int d, input int k);
    int p, le, he;
    en = 1'b0;
    repeat (12) @(negedge clk);
    lo_c = CW'(l); hi_c = CW'(h); half = dv; dly = d; stretch_k = k;
    repeat (6) @(negedge clk);
    p  = dv ? 2 : 1;
    le = ((l == 0) ? 1 : l) * p + SYNC + 1 + d;
    he = ((h == 0) ? 1 : h) * p + SYNC + 1 + d + k;
    for (int i = 0; i < 3; i++) begin
      exp_len.push_back(le); exp_low.push_back(1'b1);
      exp_len.push_back(he); exp_low.push_back(1'b0);
    end
    cur_tag = tag;
    started = 1'b0;
    mon_on  = 1'b1;
    en = 1'b1;
    wait (mon_on == 1'b0);
    @(negedge clk);
    en = 1'b0;
    stretch_k = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset pull", int'(pull), 0);
    check("R8 reset rise", int'(rise_s), 0);
    check("R8 reset fall", int'(fall_s), 0);

    run_case("R1/R2 basic", 5, 7, 1'b0, 0, 0);
    run_case("R4 half rate", 3, 4, 1'b1, 0, 0);
    run_case("R5 zero counts", 0, 0, 1'b0, 0, 0);
    run_case("R3 bus delay", 4, 6, 1'b0, 2, 0);
    run_case("R3 slave stretch", 4, 6, 1'b0, 0, 9);
    run_case("R5/R4 mixed", 0, 2, 1'b1, 1, 0);

    // R6: drop enable in mid low phase
    lo_c = 8'd20; hi_c = 8'd5; half = 1'b0; dly = 0;
    repeat (12) @(negedge clk);
    en = 1'b1;
    repeat (8) @(negedge clk);
    check("R6 pulling before disable", int'(pull), 1);
    en = 1'b0;
    @(negedge clk);
    check("R6 released after disable", int'(pull), 0);
    repeat (5) @(negedge clk);
    check("R6 stays released", int'(pull), 0);
    run_case("R6 restart", 2, 3, 1'b0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule